// File: doc/BRIEF.md
# Register-List Stack Mover

This block carries out a multi-register store to, or load from, a stack that grows toward lower addresses in a byte-addressed, word-organised memory. A 16-bit mask names the registers to move. An operation select picks store (push) or load (pop), and a single-cycle start strobe launches the operation. The block owns the stack pointer. It reads register values through a register-file read port while storing, and writes them back through a register-file write port while loading.

The transfer moves one word per accepted memory cycle, always from the lowest address to the highest, and the lowest-numbered register maps to the lowest address. After the last word, the stack pointer takes its new value in the same cycle that a one-cycle completion pulse appears. Software never adjusts the pointer separately. An empty mask finishes at once, without touching memory or the pointer.

Top module: `stack_list_mover`

## Requirements
- R1: A push with N bits set in the mask leaves the stack pointer at its old value minus 4×N.
- R2: After a push, the register with the lowest index in the mask is stored at the new stack pointer, and each further register in the mask, in rising index order, is stored 4 bytes higher. Starting from pointer 0x20002480, pushing registers 0, 1 and 2 stores them at 0x20002474, 0x20002478 and 0x2000247C and leaves the pointer at 0x20002474.
- R3: A pop loads the lowest-index registers in the mask from the lowest addresses, starting at the old stack pointer. It leaves the stack pointer at its old value plus 4×N. Loaded values appear on the register write port only in a cycle where the memory accepts a read (`mem_we_o` low).
- R4: Memory transfers run in ascending address order, 4 bytes apart, with one word completing per cycle in which `mem_req_o` and `mem_ready_i` are both high. While ready is low, the request and its address stay unchanged. A list of N registers makes exactly N transfers.
- R5: An all-zero mask raises `done_o` in the cycle after start, makes no memory request and leaves the stack pointer unchanged.
- R6: The two low bits of the stack pointer read as zero at all times, including after reset with a misaligned initial value (0x10000007 yields 0x10000004).
- R7: `busy_o` rises the cycle after an accepted start and stays high up to and including the cycle of `done_o`. A start strobe while busy, of any mask or operation, has no effect on the transfers or the final pointer.
- R8: `done_o` is a single-cycle pulse in the cycle after the last transfer, and the updated stack pointer is already visible in that cycle.
- R9: After reset, `busy_o`, `done_o` and `mem_req_o` are low and the stack pointer equals the aligned `SP_INIT` parameter (default 0x20002480).
- R10: During a push, `mem_we_o` is high and `mem_wdata_o` carries the register-file value for the index on `rf_rd_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_pop_i | input | 1 | 0 = push (store), 1 = pop (load) |
| mask_i | input | NUM_REGS | Register list, bit i selects register i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | ADDR_W | Current stack pointer |
| rf_rd_idx_o | output | IDX_W | Register-file read index |
| rf_rd_data_i | input | DATA_W | Register-file read data, combinational |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | IDX_W | Register-file write index |
| rf_wr_data_o | output | DATA_W | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts the current request |

## Verification
A corrupted remaining-list register shows up at the ports within one transfer. The register index is then wrong, the transfer count differs from the mask population, or `done_o` comes early or late. A wrong address counter shows in the very next accepted transfer as a missing 4-byte step. A stack pointer that drifts from its expected value is seen at the latest in the `done_o` cycle, and it also corrupts where every later operation places its data. Random ready stalls keep the address-hold rule under test, and misplaced data surfaces when the block's own stores are popped back.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BYTE_SHIFT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_FIN  = 2'd2
  } mover_state_t;
endpackage

// File: rtl/stk_pick.sv
// Lowest-set-bit picker: prefix-OR chain built with generate.
module stk_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  logic [N:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign below[i+1] = below[i] | vec[i];
    assign onehot[i]  = vec[i] & ~below[i];
  end

  assign found = below[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/stk_popcnt.sv
// Population count of a register mask.
module stk_popcnt #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/stk_sp_reg.sv
// Stack pointer register; low address bits are cleared on reset and on every write.
module stk_sp_reg #(
  parameter int unsigned          AW   = 32,
  parameter logic [AW-1:0]        INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(stk_pkg::WORD_BYTES - 1);
  localparam logic [AW-1:0] INIT_ALIGNED = INIT & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= INIT_ALIGNED;
    else if (wr_en) sp <= wr_val & ALIGN_MASK;
  end
endmodule

// File: rtl/stack_list_mover.sv
module stack_list_mover #(
  parameter int unsigned        NUM_REGS = 16,
  parameter int unsigned        DATA_W   = 32,
  parameter int unsigned        ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  SP_INIT  = 32'h2000_2480,
  localparam int unsigned       IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                op_pop_i,
  input  logic [NUM_REGS-1:0] mask_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [ADDR_W-1:0]   sp_o,
  output logic [IDX_W-1:0]    rf_rd_idx_o,
  input  logic [DATA_W-1:0]   rf_rd_data_i,
  output logic                rf_wr_en_o,
  output logic [IDX_W-1:0]    rf_wr_idx_o,
  output logic [DATA_W-1:0]   rf_wr_data_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ready_i
);
  import stk_pkg::*;

  localparam int unsigned CNT_W = $clog2(NUM_REGS + 1);

  // Byte span covered by n words.
  function automatic logic [ADDR_W-1:0] span_bytes(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) << BYTE_SHIFT;
  endfunction

  // First address touched by an operation.
  function automatic logic [ADDR_W-1:0] first_addr(input logic [ADDR_W-1:0] sp,
                                                   input logic pop,
                                                   input logic [CNT_W-1:0] n);
    return pop ? sp : sp - span_bytes(n);
  endfunction

  // Pointer value after an operation completes.
  function automatic logic [ADDR_W-1:0] final_sp(input logic [ADDR_W-1:0] sp,
                                                 input logic pop,
                                                 input logic [CNT_W-1:0] n);
    return pop ? sp + span_bytes(n) : sp - span_bytes(n);
  endfunction

  mover_state_t        state_q;
  logic [NUM_REGS-1:0] pend_q;
  logic                pop_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ADDR_W-1:0]   addr_q;

  logic [CNT_W-1:0]    cnt_in;
  logic                pick_found;
  logic [IDX_W-1:0]    pick_idx;
  logic [NUM_REGS-1:0] pick_onehot;
  logic [NUM_REGS-1:0] pend_after;

  // Named events for the checker.
  logic                start_take;
  logic                beat_done;
  logic                last_beat;
  logic                sp_wr_en;
  logic [ADDR_W-1:0]   sp_wr_val;

  stk_popcnt #(.N(NUM_REGS), .CW(CNT_W)) u_cnt (
    .vec   (mask_i),
    .count (cnt_in)
  );

  stk_pick #(.N(NUM_REGS), .IW(IDX_W)) u_pick (
    .vec    (pend_q),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  stk_sp_reg #(.AW(ADDR_W), .INIT(SP_INIT)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sp_wr_en),
    .wr_val (sp_wr_val),
    .sp     (sp_o)
  );

  assign start_take = start_i && (state_q == ST_IDLE);
  assign beat_done  = (state_q == ST_MOVE) && mem_ready_i && pick_found;
  assign pend_after = pend_q & ~pick_onehot;
  assign last_beat  = beat_done && (pend_after == '0);
  assign sp_wr_en   = last_beat;
  assign sp_wr_val  = final_sp(sp_o, pop_q, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      pop_q   <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            pend_q  <= mask_i;
            pop_q   <= op_pop_i;
            cnt_q   <= cnt_in;
            addr_q  <= first_addr(sp_o, op_pop_i, cnt_in);
            state_q <= (mask_i == '0) ? ST_FIN : ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (beat_done) begin
            pend_q <= pend_after;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            if (last_beat) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign mem_req_o    = (state_q == ST_MOVE);
  assign mem_we_o     = !pop_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = rf_rd_data_i;
  assign rf_rd_idx_o  = pick_idx;
  assign rf_wr_en_o   = beat_done && pop_q;
  assign rf_wr_idx_o  = pick_idx;
  assign rf_wr_data_o = mem_rdata_i;
endmodule

// File: rtl/stk_list_chk.sv
module stk_list_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rf_wr_en_o,
  input logic              beat_done,
  input logic              last_beat,
  input logic              sp_wr_en
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done_o);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

  // R7
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  // R6
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[1:0] == 2'b00);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !last_beat) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R1
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_wr_en |=> $stable(sp_o));

  // R3
  rf_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> (mem_req_o && mem_ready_i && !mem_we_o));
endmodule

bind stack_list_mover stk_list_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sp_o        (sp_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .rf_wr_en_o  (rf_wr_en_o),
  .beat_done   (beat_done),
  .last_beat   (last_beat),
  .sp_wr_en    (sp_wr_en)
);

// File: tb/stack_list_mover_tb.sv
`timescale 1ns/1ps
module stack_list_mover_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_pop_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        busy_o, done_o;
  logic [31:0] sp_o;
  logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
  logic [31:0] rf_rd_data_i, rf_wr_data_o;
  logic        rf_wr_en_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  logic [31:0] sp2;
  logic        d2_busy, d2_done, d2_rfwe, d2_req, d2_we;
  logic [3:0]  d2_ri, d2_wi;
  logic [31:0] d2_wd, d2_addr, d2_mwd;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] rf [16];
  logic [31:0] mem [logic [31:0]];

  bit          cur_pop;
  logic [15:0] cur_mask;
  logic [31:0] exp_base;
  int          beats;

  always #2.5 clk = ~clk;

  stack_list_mover u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_pop_i(op_pop_i), .mask_i(mask_i),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o),
    .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
    .rf_wr_en_o(rf_wr_en_o), .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
  );

  stack_list_mover #(.SP_INIT(32'h1000_0007)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .start_i(1'b0), .op_pop_i(1'b0), .mask_i(16'h0),
    .busy_o(d2_busy), .done_o(d2_done), .sp_o(sp2),
    .rf_rd_idx_o(d2_ri), .rf_rd_data_i(32'h0),
    .rf_wr_en_o(d2_rfwe), .rf_wr_idx_o(d2_wi), .rf_wr_data_o(d2_wd),
    .mem_req_o(d2_req), .mem_we_o(d2_we), .mem_addr_o(d2_addr),
    .mem_wdata_o(d2_mwd), .mem_rdata_i(32'h0), .mem_ready_i(1'b0)
  );

  assign rf_rd_data_i = rf[rf_rd_idx_o];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic int pop_count(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  // Index of the k-th set bit counting from bit 0.
  function automatic int nth_reg(input logic [15:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory and register-file model plus per-transfer checks.
  always @(posedge clk) begin
    if (rst_n && mem_req_o && mem_ready_i) begin
      chk(mem_addr_o == exp_base + 32'(4 * beats), "R4 address order", mem_addr_o, exp_base + 32'(4 * beats));
      chk(int'(rf_rd_idx_o) == nth_reg(cur_mask, beats), "R2 register order", 32'(rf_rd_idx_o), 32'(nth_reg(cur_mask, beats)));
      if (cur_pop) begin
        chk(mem_we_o == 1'b0, "R3 read direction", 32'(mem_we_o), 32'h0);
        chk(rf_wr_en_o == 1'b1, "R3 rf write", 32'(rf_wr_en_o), 32'h1);
      end else begin
        chk(mem_we_o == 1'b1, "R10 write direction", 32'(mem_we_o), 32'h1);
        chk(mem_wdata_o == rf[nth_reg(cur_mask, beats)], "R10 write data", mem_wdata_o, rf[nth_reg(cur_mask, beats)]);
        mem[mem_addr_o] = mem_wdata_o;
      end
      beats++;
    end
    if (rst_n && rf_wr_en_o) rf[rf_wr_idx_o] <= rf_wr_data_o;
  end

  always @(negedge clk) begin
    mem_ready_i <= (($urandom % 10) < 7);
    mem_rdata_i <= mem_rd(mem_addr_o);
  end

  task automatic do_op(input bit pop, input logic [15:0] m, input bit poke);
    logic [31:0] sp0, exp_sp;
    logic [31:0] exp_val [16];
    int n, cycles;
    @(negedge clk);
    sp0 = sp_o;
    n = pop_count(m);
    cur_pop = pop;
    cur_mask = m;
    exp_base = pop ? sp0 : sp0 - 32'(4 * n);
    exp_sp = pop ? sp0 + 32'(4 * n) : sp0 - 32'(4 * n);
    beats = 0;
    for (int k = 0; k < n; k++) exp_val[k] = mem_rd(sp0 + 32'(4 * k));
    start_i = 1'b1; op_pop_i = pop; mask_i = m;
    @(negedge clk);
    start_i = 1'b0;
    cycles = 1;
    chk(busy_o == 1'b1, "R7 busy after start", 32'(busy_o), 32'h1);
    if (poke && !done_o) begin
      start_i = 1'b1; op_pop_i = ~pop; mask_i = ~m;
      @(negedge clk);
      start_i = 1'b0;
      cycles++;
    end
    while (!done_o && cycles < 200) begin
      chk(busy_o == 1'b1, "R7 busy until done", 32'(busy_o), 32'h1);
      @(negedge clk);
      cycles++;
    end
    chk(done_o == 1'b1, "R8 done seen", 32'(done_o), 32'h1);
    chk(sp_o == exp_sp, pop ? "R3 pop pointer" : "R1 push pointer", sp_o, exp_sp);
    chk(sp_o[1:0] == 2'b00, "R6 alignment", 32'(sp_o[1:0]), 32'h0);
    chk(beats == n, "R4 transfer count", 32'(beats), 32'(n));
    if (n == 0) begin
      chk(cycles == 1, "R5 empty list latency", 32'(cycles), 32'h1);
      chk(sp_o == sp0, "R5 empty list pointer", sp_o, sp0);
    end
    @(negedge clk);
    chk(!busy_o && !done_o, "R8 single pulse / R7 busy drop", {30'h0, busy_o, done_o}, 32'h0);
    for (int k = 0; k < n; k++) begin
      if (pop) chk(rf[nth_reg(m, k)] == exp_val[k], "R3 pop data", rf[nth_reg(m, k)], exp_val[k]);
      else     chk(mem_rd(exp_base + 32'(4 * k)) == rf[nth_reg(m, k)], "R2 push placement",
                   mem_rd(exp_base + 32'(4 * k)), rf[nth_reg(m, k)]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    rf[0] = 32'h3434_3434; rf[1] = 32'h0000_1212; rf[2] = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy_o && !done_o && !mem_req_o, "R9 reset outputs", {29'h0, busy_o, done_o, mem_req_o}, 32'h0);
    chk(sp_o == 32'h2000_2480, "R9 reset pointer", sp_o, 32'h2000_2480);
    chk(sp2 == 32'h1000_0004, "R6 misaligned init", sp2, 32'h1000_0004);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && sp_o == 32'h2000_2480, "R9 idle after reset", sp_o, 32'h2000_2480);

    // R2 worked example
    do_op(1'b0, 16'h0007, 1'b0);
    chk(sp_o == 32'h2000_2474, "R2 example pointer", sp_o, 32'h2000_2474);
    chk(mem_rd(32'h2000_2474) == 32'h3434_3434, "R2 example R0", mem_rd(32'h2000_2474), 32'h3434_3434);
    chk(mem_rd(32'h2000_2478) == 32'h0000_1212, "R2 example R1", mem_rd(32'h2000_2478), 32'h0000_1212);
    chk(mem_rd(32'h2000_247C) == 32'h0, "R2 example R2", mem_rd(32'h2000_247C), 32'h0);

    // R5 empty lists
    do_op(1'b0, 16'h0000, 1'b0);
    do_op(1'b1, 16'h0000, 1'b1);
    // Full list and sparse lists, with ignored starts (R7)
    do_op(1'b0, 16'hFFFF, 1'b1);
    for (int i = 0; i < 16; i++) rf[i] = ~rf[i];
    do_op(1'b1, 16'hFFFF, 1'b0);
    do_op(1'b0, 16'h8001, 1'b1);
    do_op(1'b1, 16'h8001, 1'b0);
    do_op(1'b0, 16'h4000, 1'b0);
    do_op(1'b1, 16'h0002, 1'b1);

    for (int t = 0; t < 150; t++) begin
      logic [15:0] m;
      m = 16'($urandom);
      if (($urandom % 4) == 0) m = m & 16'($urandom);
      if (($urandom % 2) == 0) for (int i = 0; i < 16; i++) rf[i] = $urandom;
      do_op(1'(($urandom % 2)), m, 1'(($urandom % 3) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule